// File: doc/BRIEF.md
# Intersection Signal Sequencer

This block is the sequencing core of a four-group intersection signal: a main street, a side street, and a protected left-turn group on each. It advances on a slow time-base pulse (`tick`, one pulse per counting interval) and steps through main green, main yellow, an optional main left-turn phase, side green, side yellow and an optional side left-turn phase. Each light group gets a 3-bit code that names what it should show. The flashing waveform and the lamp drivers are built elsewhere from that code.

Phase decisions are taken only at the end of the two yellow phases. At the end of main yellow the block looks at the main left-turn request. At the end of side yellow it checks a manual-override edge first, then the night input, then the side left-turn request. A manual override puts every group into flashing red until a second manual edge arrives. Night operation flashes yellow on the main-street groups and red on the side-street groups until night is removed or a manual edge arrives. The request, night and manual inputs are synchronised with two flip-flops. Manual acts only on its rising edge.

States: `ST_IDLE` (all red, waiting for start), `ST_MAIN_GO`, `ST_MAIN_WARN`, `ST_MTURN_GO`, `ST_MTURN_WARN`, `ST_SIDE_GO`, `ST_SIDE_WARN`, `ST_STURN_GO`, `ST_STURN_WARN`, `ST_ALL_STOP` (override), `ST_NIGHT`. Transitions:
- IDLE→MAIN_GO on start.
- MAIN_GO→MAIN_WARN, MTURN_GO→MTURN_WARN, SIDE_GO→SIDE_WARN and STURN_GO→STURN_WARN when the phase time runs out.
- MAIN_WARN→MTURN_GO or →SIDE_GO, and MTURN_WARN→SIDE_GO, on timeout.
- SIDE_WARN→ALL_STOP, →NIGHT, →STURN_GO or →MAIN_GO on timeout, chosen by priority.
- STURN_WARN→MAIN_GO on timeout.
- ALL_STOP→NIGHT or →MAIN_GO on a manual edge.
- NIGHT→ALL_STOP on a manual edge, and NIGHT→MAIN_GO when night drops.

Top module: `crossing_ctrl`

## Requirements
- R1: While reset is held, and after reset until `start` is seen high in a clock cycle, all four groups show red. The cycle after that, the main group shows green.
- R2: The main green phase lasts exactly GREEN_TICKS tick pulses and is followed by main yellow. Main yellow lasts YELLOW_TICKS pulses.
- R3: When main yellow ends, a synchronised main left-turn request selects main-turn green (LEFT_TICKS pulses) and then main-turn yellow (YELLOW_TICKS pulses) before side green. Without the request, side green follows main yellow directly.
- R4: Side green lasts GREEN_TICKS pulses and is followed by side yellow, which lasts YELLOW_TICKS pulses.
- R5: When side yellow ends, the block picks the first true item in this order and goes to its state. A manual rising edge seen at any cycle of side yellow goes to override. Night goes to night mode. A side left-turn request goes to side-turn green (LEFT_TICKS) and then side-turn yellow (YELLOW_TICKS), then main green. Otherwise the block goes to main green.
- R6: In override all four groups show flashing red. The block stays there until the next manual rising edge. It then enters night mode if night is high, and main green otherwise.
- R7: In night mode the main and main-turn groups show flashing yellow and the side and side-turn groups show flashing red. A manual rising edge goes to override, and this takes precedence. Otherwise night going low returns the block to main green.
- R8: Group codes are red 3'b001, yellow 3'b010, green 3'b100, flashing red 3'b101 and flashing yellow 3'b110. No other code appears.
- R9: Requests, night and manual pass through two synchroniser flip-flops. Only a manual rising edge acts: a manual level held high does not leave override. A manual edge during a green phase is ignored. Requests are only looked at when a yellow phase ends.
- R10: At no time does more than one group show steady green or steady yellow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time-base pulse |
| start | input | 1 | Leaves the all-red idle state |
| main_left_req | input | 1 | Main left-turn request (asynchronous) |
| side_left_req | input | 1 | Side left-turn request (asynchronous) |
| night | input | 1 | Night operation level (asynchronous) |
| manual | input | 1 | Manual override control (asynchronous, edge acts) |
| main_lamp | output | 3 | Main-street through group code |
| main_turn_lamp | output | 3 | Main-street left-turn group code |
| side_lamp | output | 3 | Side-street through group code |
| side_turn_lamp | output | 3 | Side-street left-turn group code |

## Verification
The group codes decode straight from the state register, so a phase change shows on the outputs in the cycle after the clock edge at which the closing tick was sampled. A change on a request, night or manual input has to pass two synchroniser stages, and manual also passes an edge register, before it can affect a decision. A manual edge therefore takes effect no earlier than the third edge after the input changes. The bench keeps a cycle-level reference model with the same latencies, steps it once on every rising edge, and compares all four codes on the falling edge that follows. In the directed parts the bench holds `tick` low, so that a manual edge is sure to arrive inside side yellow or inside a green phase.

// File: rtl/crossing_pkg.sv
package crossing_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_MAIN_GO    = 4'd1,
        ST_MAIN_WARN  = 4'd2,
        ST_MTURN_GO   = 4'd3,
        ST_MTURN_WARN = 4'd4,
        ST_SIDE_GO    = 4'd5,
        ST_SIDE_WARN  = 4'd6,
        ST_STURN_GO   = 4'd7,
        ST_STURN_WARN = 4'd8,
        ST_ALL_STOP   = 4'd9,
        ST_NIGHT      = 4'd10
    } phase_e;

    typedef enum logic [2:0] {
        LAMP_RED  = 3'b001,
        LAMP_YEL  = 3'b010,
        LAMP_GRN  = 3'b100,
        LAMP_FRED = 3'b101,
        LAMP_FYEL = 3'b110
    } lamp_e;

    // positions of the asynchronous inputs in the synchroniser vector
    localparam int IN_MLEFT  = 0;
    localparam int IN_SLEFT  = 1;
    localparam int IN_NIGHT  = 2;
    localparam int IN_MANUAL = 3;
    localparam int IN_COUNT  = 4;

endpackage

// File: rtl/crossing_sync.sv
module crossing_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/crossing_edge.sv
module crossing_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/crossing_timer.sv
module crossing_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= '0;
        else if (run && tick)    cnt <= cnt + 1'b1;
    end

    assign done = run && tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/crossing_fsm.sv
module crossing_fsm
    import crossing_pkg::*;
#(
    parameter int GREEN_TICKS  = 6,
    parameter int YELLOW_TICKS = 1,
    parameter int LEFT_TICKS   = 3,
    parameter int CW           = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mleft,
    input  logic          sleft,
    input  logic          night_s,
    input  logic          man_pulse,
    input  logic          done,
    output logic          run,
    output logic          restart,
    output logic [CW-1:0] limit,
    output logic [2:0]    main_lamp,
    output logic [2:0]    main_turn_lamp,
    output logic [2:0]    side_lamp,
    output logic [2:0]    side_turn_lamp
);
    phase_e state, next;
    logic   man_pend;

    // state register and the manual edge held during side yellow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            man_pend <= 1'b0;
        end else begin
            state    <= next;
            man_pend <= (state == ST_SIDE_WARN && next == ST_SIDE_WARN)
                        ? (man_pend | man_pulse) : 1'b0;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:       if (start) next = ST_MAIN_GO;
            ST_MAIN_GO:    if (done)  next = ST_MAIN_WARN;
            ST_MAIN_WARN:  if (done)  next = mleft ? ST_MTURN_GO : ST_SIDE_GO;
            ST_MTURN_GO:   if (done)  next = ST_MTURN_WARN;
            ST_MTURN_WARN: if (done)  next = ST_SIDE_GO;
            ST_SIDE_GO:    if (done)  next = ST_SIDE_WARN;
            ST_SIDE_WARN: begin
                if (done) begin
                    if (man_pend || man_pulse) next = ST_ALL_STOP;
                    else if (night_s)          next = ST_NIGHT;
                    else if (sleft)            next = ST_STURN_GO;
                    else                       next = ST_MAIN_GO;
                end
            end
            ST_STURN_GO:   if (done)  next = ST_STURN_WARN;
            ST_STURN_WARN: if (done)  next = ST_MAIN_GO;
            ST_ALL_STOP:   if (man_pulse) next = night_s ? ST_NIGHT : ST_MAIN_GO;
            ST_NIGHT: begin
                if (man_pulse)     next = ST_ALL_STOP;
                else if (!night_s) next = ST_MAIN_GO;
            end
            default:       next = ST_IDLE;
        endcase
    end

    // phase length selection for the timer
    always_comb begin
        run   = 1'b1;
        limit = CW'(YELLOW_TICKS);
        unique case (state)
            ST_MAIN_GO, ST_SIDE_GO:   limit = CW'(GREEN_TICKS);
            ST_MTURN_GO, ST_STURN_GO: limit = CW'(LEFT_TICKS);
            ST_MAIN_WARN, ST_MTURN_WARN,
            ST_SIDE_WARN, ST_STURN_WARN: limit = CW'(YELLOW_TICKS);
            default:                  run   = 1'b0;
        endcase
    end

    assign restart = (next != state);

    // Moore output decode
    always_comb begin
        main_lamp      = LAMP_RED;
        main_turn_lamp = LAMP_RED;
        side_lamp      = LAMP_RED;
        side_turn_lamp = LAMP_RED;
        unique case (state)
            ST_MAIN_GO:    main_lamp      = LAMP_GRN;
            ST_MAIN_WARN:  main_lamp      = LAMP_YEL;
            ST_MTURN_GO:   main_turn_lamp = LAMP_GRN;
            ST_MTURN_WARN: main_turn_lamp = LAMP_YEL;
            ST_SIDE_GO:    side_lamp      = LAMP_GRN;
            ST_SIDE_WARN:  side_lamp      = LAMP_YEL;
            ST_STURN_GO:   side_turn_lamp = LAMP_GRN;
            ST_STURN_WARN: side_turn_lamp = LAMP_YEL;
            ST_ALL_STOP: begin
                main_lamp      = LAMP_FRED;
                main_turn_lamp = LAMP_FRED;
                side_lamp      = LAMP_FRED;
                side_turn_lamp = LAMP_FRED;
            end
            ST_NIGHT: begin
                main_lamp      = LAMP_FYEL;
                main_turn_lamp = LAMP_FYEL;
                side_lamp      = LAMP_FRED;
                side_turn_lamp = LAMP_FRED;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl
    import crossing_pkg::*;
#(
    parameter int GREEN_TICKS  = 6,
    parameter int YELLOW_TICKS = 1,
    parameter int LEFT_TICKS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic       main_left_req,
    input  logic       side_left_req,
    input  logic       night,
    input  logic       manual,
    output logic [2:0] main_lamp,
    output logic [2:0] main_turn_lamp,
    output logic [2:0] side_lamp,
    output logic [2:0] side_turn_lamp
);
    localparam int MAX_GY  = (GREEN_TICKS > YELLOW_TICKS) ? GREEN_TICKS : YELLOW_TICKS;
    localparam int MAX_T   = (MAX_GY > LEFT_TICKS) ? MAX_GY : LEFT_TICKS;
    localparam int CW      = $clog2(MAX_T + 1);

    logic [IN_COUNT-1:0] raw_in, sync_in;
    logic                man_pulse;
    logic                run, restart, done;
    logic [CW-1:0]       limit;

    always_comb begin
        raw_in            = '0;
        raw_in[IN_MLEFT]  = main_left_req;
        raw_in[IN_SLEFT]  = side_left_req;
        raw_in[IN_NIGHT]  = night;
        raw_in[IN_MANUAL] = manual;
    end

    crossing_sync #(.WIDTH(IN_COUNT), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_in)
    );

    crossing_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_in[IN_MANUAL]),
        .rise  (man_pulse)
    );

    crossing_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .restart (restart),
        .limit   (limit),
        .done    (done)
    );

    crossing_fsm #(
        .GREEN_TICKS  (GREEN_TICKS),
        .YELLOW_TICKS (YELLOW_TICKS),
        .LEFT_TICKS   (LEFT_TICKS),
        .CW           (CW)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .mleft          (sync_in[IN_MLEFT]),
        .sleft          (sync_in[IN_SLEFT]),
        .night_s        (sync_in[IN_NIGHT]),
        .man_pulse      (man_pulse),
        .done           (done),
        .run            (run),
        .restart        (restart),
        .limit          (limit),
        .main_lamp      (main_lamp),
        .main_turn_lamp (main_turn_lamp),
        .side_lamp      (side_lamp),
        .side_turn_lamp (side_turn_lamp)
    );
endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk #(
    parameter int GREEN_TICKS = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       start,
    input logic       man_pulse,
    input logic [2:0] main_lamp,
    input logic [2:0] main_turn_lamp,
    input logic [2:0] side_lamp,
    input logic [2:0] side_turn_lamp
);
    localparam logic [2:0] C_RED  = 3'b001;
    localparam logic [2:0] C_YEL  = 3'b010;
    localparam logic [2:0] C_GRN  = 3'b100;
    localparam logic [2:0] C_FRED = 3'b101;
    localparam logic [2:0] C_FYEL = 3'b110;

    logic seen_start;
    int   green_ticks_q;
    logic all_fred;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_start <= 1'b0;
        else if (start) seen_start <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    green_ticks_q <= 0;
        else if (main_lamp != C_GRN)   green_ticks_q <= 0;
        else if (tick)                 green_ticks_q <= green_ticks_q + 1;
    end

    assign all_fred = (main_lamp == C_FRED) && (main_turn_lamp == C_FRED) &&
                      (side_lamp == C_FRED) && (side_turn_lamp == C_FRED);

    function automatic logic legal(input logic [2:0] c);
        return (c == C_RED) || (c == C_YEL) || (c == C_GRN) ||
               (c == C_FRED) || (c == C_FYEL);
    endfunction

    function automatic logic active(input logic [2:0] c);
        return (c == C_GRN) || (c == C_YEL);
    endfunction

    assert_idle_red_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> (main_lamp == C_RED && main_turn_lamp == C_RED &&
                         side_lamp == C_RED && side_turn_lamp == C_RED));

    assert_green_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(main_lamp) == C_GRN && main_lamp != C_GRN) |-> green_ticks_q == GREEN_TICKS);

    assert_after_main_yel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(main_lamp) == C_YEL && main_lamp != C_YEL) |->
        (main_turn_lamp == C_GRN || side_lamp == C_GRN));

    assert_override_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_fred && !man_pulse) |=> all_fred);

    assert_night_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_lamp == C_FYEL) |-> (main_turn_lamp == C_FYEL &&
                                   side_lamp == C_FRED && side_turn_lamp == C_FRED));

    assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        legal(main_lamp) && legal(main_turn_lamp) && legal(side_lamp) && legal(side_turn_lamp));

    assert_single_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({active(main_lamp), active(main_turn_lamp),
                    active(side_lamp), active(side_turn_lamp)}) <= 1);
endmodule

bind crossing_ctrl crossing_ctrl_chk #(.GREEN_TICKS(GREEN_TICKS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .start          (start),
    .man_pulse      (man_pulse),
    .main_lamp      (main_lamp),
    .main_turn_lamp (main_turn_lamp),
    .side_lamp      (side_lamp),
    .side_turn_lamp (side_turn_lamp)
);

// File: tb/crossing_ctrl_bench.sv
module crossing_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GT = 6;
    localparam int YT = 1;
    localparam int LT = 3;
    localparam int TICK_GAP = 3;

    // reference states
    localparam int S_IDLE = 0, S_MG = 1, S_MY = 2, S_MTG = 3, S_MTY = 4, S_SG = 5,
                   S_SY = 6, S_STG = 7, S_STY = 8, S_OVR = 9, S_NGT = 10;
    // R8 codes
    localparam logic [2:0] RED = 3'b001, YEL = 3'b010, GRN = 3'b100,
                           FRED = 3'b101, FYEL = 3'b110;

    logic clk = 0, rst_n = 0, tick = 0, start = 0;
    logic main_left_req = 0, side_left_req = 0, night = 0, manual = 0;
    logic [2:0] main_lamp, main_turn_lamp, side_lamp, side_turn_lamp;

    int n_checks = 0, n_fail = 0;
    int tick_phase = 0;
    logic tick_en = 1;

    // reference model state
    int   m_st = S_IDLE;
    int   m_cnt = 0;
    logic m_pend = 0, m_prev = 0;
    logic [3:0] s1 = '0, s2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crossing_ctrl #(.GREEN_TICKS(GT), .YELLOW_TICKS(YT), .LEFT_TICKS(LT)) u_crossing_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .main_left_req(main_left_req), .side_left_req(side_left_req),
        .night(night), .manual(manual),
        .main_lamp(main_lamp), .main_turn_lamp(main_turn_lamp),
        .side_lamp(side_lamp), .side_turn_lamp(side_turn_lamp)
    );

    function automatic string tag_of(int st);
        case (st)
            S_IDLE:         return "R1";
            S_MG:           return "R2";
            S_MY, S_MTG, S_MTY: return "R3";
            S_SG:           return "R4";
            S_SY, S_STG, S_STY: return "R5";
            S_OVR:          return "R6";
            default:        return "R7";
        endcase
    endfunction

    // expected {main, main_turn, side, side_turn}
    function automatic logic [11:0] exp_lamps(int st);
        case (st)
            S_MG:  return {GRN, RED, RED, RED};
            S_MY:  return {YEL, RED, RED, RED};
            S_MTG: return {RED, GRN, RED, RED};
            S_MTY: return {RED, YEL, RED, RED};
            S_SG:  return {RED, RED, GRN, RED};
            S_SY:  return {RED, RED, YEL, RED};
            S_STG: return {RED, RED, RED, GRN};
            S_STY: return {RED, RED, RED, YEL};
            S_OVR: return {FRED, FRED, FRED, FRED};
            S_NGT: return {FYEL, FYEL, FRED, FRED};
            default: return {RED, RED, RED, RED};
        endcase
    endfunction

    function automatic int dur_of(int st);
        if (st == S_MG || st == S_SG) return GT;
        if (st == S_MTG || st == S_STG) return LT;
        return YT;
    endfunction

    function automatic logic timed(int st);
        return (st >= S_MG) && (st <= S_STY);
    endfunction

    task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: lamps got %03b_%03b_%03b_%03b expected %03b_%03b_%03b_%03b at %0t",
                     tag, got[11:9], got[8:6], got[5:3], got[2:0],
                     exp[11:9], exp[8:6], exp[5:3], exp[2:0], $time);
        end
    endtask

    // one clock of the reference model, same input latencies as R9 demands
    task automatic model_update();
        logic pulse, done;
        int   nxt;
        pulse = s2[3] & ~m_prev;
        done  = tick && timed(m_st) && (m_cnt == dur_of(m_st) - 1);
        nxt   = m_st;
        case (m_st)
            S_IDLE: if (start) nxt = S_MG;
            S_MG:   if (done) nxt = S_MY;
            S_MY:   if (done) nxt = s2[0] ? S_MTG : S_SG;
            S_MTG:  if (done) nxt = S_MTY;
            S_MTY:  if (done) nxt = S_SG;
            S_SG:   if (done) nxt = S_SY;
            S_SY:   if (done) begin
                        if (m_pend || pulse) nxt = S_OVR;
                        else if (s2[2])      nxt = S_NGT;
                        else if (s2[1])      nxt = S_STG;
                        else                 nxt = S_MG;
                    end
            S_STG:  if (done) nxt = S_STY;
            S_STY:  if (done) nxt = S_MG;
            S_OVR:  if (pulse) nxt = s2[2] ? S_NGT : S_MG;
            default: begin
                if (pulse)       nxt = S_OVR;
                else if (!s2[2]) nxt = S_MG;
            end
        endcase
        m_pend = (m_st == S_SY && nxt == S_SY) ? (m_pend | pulse) : 1'b0;
        if (nxt != m_st)                m_cnt = 0;
        else if (timed(m_st) && tick)   m_cnt = m_cnt + 1;
        m_prev = s2[3];
        s2 = s1;
        s1 = {manual, night, side_left_req, main_left_req};
        m_st = nxt;
    endtask

    task automatic step();
        logic [11:0] got, e;
        @(posedge clk);
        model_update();
        @(negedge clk);
        got = {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp};
        e = exp_lamps(m_st);
        check(tag_of(m_st), got, e);
        // R10: never two groups in steady green/yellow
        n_checks++;
        if ($countones({main_lamp == GRN || main_lamp == YEL, main_turn_lamp == GRN || main_turn_lamp == YEL,
                        side_lamp == GRN || side_lamp == YEL, side_turn_lamp == GRN || side_turn_lamp == YEL}) > 1) begin
            n_fail++;
            $display("FAIL R10: several active groups %03b %03b %03b %03b expected at most one",
                     main_lamp, main_turn_lamp, side_lamp, side_turn_lamp);
        end
        tick_phase = (tick_phase + 1) % TICK_GAP;
        tick = tick_en && (tick_phase == 0);
    endtask

    task automatic wait_state(int st);
        for (int k = 0; k < 2000 && m_st != st; k++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1A2B_3C4D);
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {RED, RED, RED, RED});
        rst_n = 1;
        // R1: stays red with ticks running and no start
        for (int k = 0; k < 12; k++) step();
        start = 1;
        step();
        start = 0;
        // R8: main green code is 3'b100 right after start
        check("R8", {main_lamp, 9'b0}, {3'b100, 9'b0});

        // constrained random traffic
        for (int k = 0; k < 15000; k++) begin
            if ($urandom_range(0, 19) == 0) main_left_req = ~main_left_req;
            if ($urandom_range(0, 19) == 0) side_left_req = ~side_left_req;
            if ($urandom_range(0, 299) == 0) night = ~night;
            if ($urandom_range(0, 29) == 0) manual = ~manual;
            step();
        end

        // directed: settle to normal cycle
        manual = 0; night = 0; main_left_req = 0; side_left_req = 0;
        for (int k = 0; k < 6; k++) step();
        if (m_st == S_OVR) begin manual = 1; for (int k = 0; k < 6; k++) step(); manual = 0; end
        for (int k = 0; k < 6; k++) step();

        // R9: manual edge during main green is ignored
        wait_state(S_MG);
        tick_en = 0;
        manual = 1;
        for (int k = 0; k < 6; k++) step();
        check("R9", {main_lamp, 9'b0}, {GRN, 9'b0});
        manual = 0;
        for (int k = 0; k < 4; k++) step();
        tick_en = 1;

        // R5: manual edge inside side yellow leads to override, priority over night
        wait_state(S_SY);
        tick_en = 0;
        night = 1;
        manual = 1;
        for (int k = 0; k < 6; k++) step();
        tick_en = 1;
        for (int k = 0; k < 6; k++) step();
        check("R6", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {FRED, FRED, FRED, FRED});
        // R9: a held manual level does not release override
        for (int k = 0; k < 20; k++) step();
        check("R9", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {FRED, FRED, FRED, FRED});
        // R6: second edge with night high enters night mode
        manual = 0;
        for (int k = 0; k < 4; k++) step();
        manual = 1;
        for (int k = 0; k < 5; k++) step();
        check("R7", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {FYEL, FYEL, FRED, FRED});
        // R7: manual edge in night returns to override
        manual = 0;
        for (int k = 0; k < 4; k++) step();
        manual = 1;
        for (int k = 0; k < 5; k++) step();
        check("R7", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {FRED, FRED, FRED, FRED});
        // R6: edge with night low resumes at main green
        night = 0;
        manual = 0;
        for (int k = 0; k < 4; k++) step();
        manual = 1;
        for (int k = 0; k < 5; k++) step();
        check("R6", {main_lamp, 9'b0}, {GRN, 9'b0});
        manual = 0;

        // R3 and R5: both turn phases taken
        main_left_req = 1; side_left_req = 1;
        wait_state(S_MTG);
        check("R3", {main_turn_lamp, 9'b0}, {GRN, 9'b0});
        wait_state(S_STG);
        check("R5", {side_turn_lamp, 9'b0}, {GRN, 9'b0});
        // R7: night at side yellow end, then release
        main_left_req = 0; side_left_req = 0; night = 1;
        wait_state(S_NGT);
        check("R7", {main_lamp, main_turn_lamp, side_lamp, side_turn_lamp}, {FYEL, FYEL, FRED, FRED});
        night = 0;
        for (int k = 0; k < 5; k++) step();
        check("R7", {main_lamp, 9'b0}, {GRN, 9'b0});
        for (int k = 0; k < 60; k++) step();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule